// File: doc/BRIEF.md
# Zero-Padded Matrix Linear Convolver

This block forms the full linear convolution of two short unsigned sequences. It reuses the matrix-times-vector datapath of a circular convolver. One operand is placed in a tall Toeplitz matrix with `2P-1` rows and `P` columns. Its first column holds the operand followed by zero rows, and every later column is the column to its left moved down by one row. The matrix is multiplied by the other operand, and each matrix row yields one output sample.

A pulse on `start_i` while the block is idle latches both operands. On the clock edges that follow, the block presents the `2P-1` results one per cycle, in ascending index order, with a valid flag. The final result also carries a last flag. While a run is in progress, `busy_o` is high and any further starts are ignored. With the default settings, two 4-sample sequences of 4-bit samples produce seven 10-bit results.

Top module: `lconv_engine`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `busy_o`, `out_valid_o` and `out_last_o` are 0.
- R2: A `start_i` sampled high at a clock edge while `busy_o` is 0 latches `x_i` and `h_i`. From that edge on, `out_valid_o` is 1 with `out_idx_o` equal to 0.
- R3: Once started, `out_valid_o` stays high for exactly seven consecutive cycles. During those cycles `out_idx_o` steps 0,1,2,3,4,5,6.
- R4: `out_last_o` is 1 exactly on the valid cycle whose index is 6, and is 0 on every other cycle.
- R5: With sample n of each operand taken from bits [4n+3:4n] of its port, the result at index k equals the sum over n of x(n)·h(k−n), where terms with k−n outside 0..3 count as zero. For example, x={14,1,7,4} with h={7,8,5,2} gives {98,119,127,117,69,34,8}; x={9,2,4,1} with h={3,1,3,4} gives {27,15,41,49,21,19,4}; and x={5,2,1,4} with h={2,6,6,7} gives {10,34,44,61,44,31,28}.
- R6: A `start_i` raised while `busy_o` is 1 has no effect: the index sequence and the result values continue from the original operands.
- R7: Changes on `x_i` and `h_i` after the latching edge do not alter the results of the run in progress.
- R8: On the cycle after index 6, `busy_o` and `out_valid_o` are 0 and a new start is accepted.
- R9: All-15 operands give {225,450,675,900,675,450,225}, so no result exceeds 900 and none wraps. All-zero operands give seven zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to latch operands and begin a run |
| x_i | input | 16 | Matrix operand, sample n in bits [4n+3:4n] |
| h_i | input | 16 | Vector operand, sample n in bits [4n+3:4n] |
| busy_o | output | 1 | High while a run is in progress |
| out_valid_o | output | 1 | Result on `out_data_o` is valid |
| out_last_o | output | 1 | Marks the final result of a run |
| out_idx_o | output | 3 | Index of the presented result |
| out_data_o | output | 10 | Convolution result |

## Verification
The assertions take for granted that `start_i` is sampled only at clock edges. They also take for granted that operand ports may hold any value at any time, because the block reads them only at the accepting edge. The bench drives inputs away from the clock edge. It deliberately raises `start_i` during runs and scrambles `x_i` and `h_i` between starts, so the properties on held operands and on ignored starts are exercised under hostile input. Operand values cover random samples, the three worked examples, and the all-zero and all-15 extremes.

// File: rtl/lconv_pkg.sv
package lconv_pkg;
    typedef enum logic {
        LC_IDLE = 1'b0,
        LC_RUN  = 1'b1
    } lc_state_e;
endpackage

// File: rtl/lconv_row.sv
// One row of the zero-padded Toeplitz matrix times the vector operand.
module lconv_row #(
    parameter int unsigned PTS      = 4,
    parameter int unsigned SAMPLE_W = 4,
    parameter int unsigned ROW      = 0,
    parameter int unsigned ACC_W    = 10
) (
    input  logic [PTS*SAMPLE_W-1:0] x_i,
    input  logic [PTS*SAMPLE_W-1:0] h_i,
    output logic [ACC_W-1:0]        sum_o
);
    localparam int unsigned PROD_W = 2 * SAMPLE_W;

    logic [PROD_W-1:0] prod [PTS];

    // Column n of this row holds x(ROW-n); positions before x(0) or past
    // x(PTS-1) are the zero padding.
    for (genvar n = 0; n < PTS; n++) begin : g_col
        localparam int XI = int'(ROW) - n;
        if (XI >= 0 && XI < int'(PTS)) begin : g_tap
            assign prod[n] = PROD_W'(x_i[XI*SAMPLE_W +: SAMPLE_W])
                           * PROD_W'(h_i[n*SAMPLE_W +: SAMPLE_W]);
        end else begin : g_pad
            assign prod[n] = '0;
        end
    end

    always_comb begin
        sum_o = '0;
        for (int n = 0; n < int'(PTS); n++) begin
            sum_o = sum_o + ACC_W'(prod[n]);
        end
    end
endmodule

// File: rtl/lconv_ctrl.sv
// Run sequencer: idle/run state and output index.
module lconv_ctrl
    import lconv_pkg::*;
#(
    parameter int unsigned OUT_LEN = 7,
    parameter int unsigned IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(OUT_LEN - 1);

    typedef struct packed {
        lc_state_e        state;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = 1'b0;
        case (st_q.state)
            LC_IDLE: begin
                if (start_i) begin
                    accept_o   = 1'b1;
                    st_d.state = LC_RUN;
                    st_d.idx   = '0;
                end
            end
            LC_RUN: begin
                if (st_q.idx == IDX_END) begin
                    st_d.state = LC_IDLE;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: st_d = '{state: LC_IDLE, idx: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: LC_IDLE, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.state == LC_RUN);
    assign valid_o = busy_o;
    assign idx_o   = st_q.idx;
    assign last_o  = busy_o && (st_q.idx == IDX_END);

    // R2: an idle start leads to index 0 on the next cycle
    a_r2_first_index: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (valid_o && idx_o == '0));

    // R3: indices advance by one while the run continues
    a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (valid_o && idx_o == $past(idx_o) + 1'b1));

    // R6: a run is not cut short or restarted
    a_r6_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> busy_o);

    // R8: idle follows the final result
    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (!busy_o && !valid_o));
endmodule

// File: rtl/lconv_engine.sv
// Linear convolution through a zero-padded Toeplitz matrix product.
module lconv_engine #(
    parameter int unsigned PTS      = 4,
    parameter int unsigned SAMPLE_W = 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     start_i,
    input  logic [PTS*SAMPLE_W-1:0]                  x_i,
    input  logic [PTS*SAMPLE_W-1:0]                  h_i,
    output logic                                     busy_o,
    output logic                                     out_valid_o,
    output logic                                     out_last_o,
    output logic [$clog2(2*PTS-1)-1:0]               out_idx_o,
    output logic [2*SAMPLE_W+$clog2(PTS)-1:0]        out_data_o
);
    localparam int unsigned OUT_LEN = 2 * PTS - 1;
    localparam int unsigned IDX_W   = $clog2(OUT_LEN);
    localparam int unsigned PROD_W  = 2 * SAMPLE_W;
    localparam int unsigned ACC_W   = PROD_W + $clog2(PTS);
    localparam int unsigned VEC_W   = PTS * SAMPLE_W;
    localparam int unsigned MAX_OUT = PTS * ((2 ** SAMPLE_W) - 1) * ((2 ** SAMPLE_W) - 1);

    typedef struct packed {
        logic [VEC_W-1:0] x;
        logic [VEC_W-1:0] h;
    } ops_t;

    ops_t ops_d, ops_q;
    logic accept;
    logic [ACC_W-1:0] row_sum [OUT_LEN];

    lconv_ctrl #(
        .OUT_LEN (OUT_LEN),
        .IDX_W   (IDX_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .valid_o  (out_valid_o),
        .last_o   (out_last_o),
        .idx_o    (out_idx_o)
    );

    always_comb begin
        ops_d = ops_q;
        if (accept) begin
            ops_d.x = x_i;
            ops_d.h = h_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ops_q <= '0;
        end else begin
            ops_q <= ops_d;
        end
    end

    for (genvar r = 0; r < OUT_LEN; r++) begin : g_row
        lconv_row #(
            .PTS      (PTS),
            .SAMPLE_W (SAMPLE_W),
            .ROW      (r),
            .ACC_W    (ACC_W)
        ) row_i (
            .x_i   (ops_q.x),
            .h_i   (ops_q.h),
            .sum_o (row_sum[r])
        );
    end

    always_comb begin
        out_data_o = '0;
        for (int r = 0; r < int'(OUT_LEN); r++) begin
            if (out_valid_o && out_idx_o == IDX_W'(r)) begin
                out_data_o = row_sum[r];
            end
        end
    end

    // R7: latched operands do not move during a run
    a_r7_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ops_q));

    // R9: no result exceeds the largest possible convolution value
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (int'(out_data_o) <= int'(MAX_OUT)));
endmodule

// File: tb/lconv_engine_tb.sv
module lconv_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NO = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [15:0] x_i = '0;
    logic [15:0] h_i = '0;
    logic busy_o, out_valid_o, out_last_o;
    logic [2:0] out_idx_o;
    logic [9:0] out_data_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // behavioural model state
    bit m_busy = 0;
    int m_idx = 0;
    int m_x [NP];
    int m_h [NP];
    int got [NO];

    always #(CLK_PERIOD/2) clk = ~clk;

    lconv_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i), .h_i(h_i),
        .busy_o(busy_o), .out_valid_o(out_valid_o), .out_last_o(out_last_o),
        .out_idx_o(out_idx_o), .out_data_o(out_data_o)
    );

    function automatic int conv(int k);
        int s = 0;
        for (int n = 0; n < NP; n++) begin
            if (k - n >= 0 && k - n < NP) s += m_x[k-n] * m_h[n];
        end
        return s;
    endfunction

    function automatic logic [15:0] pack4(int a, int b, int c, int d);
        return {4'(d), 4'(c), 4'(b), 4'(a)};
    endfunction

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: apply inputs, advance model, compare at negedge
    task automatic step(bit st, logic [15:0] xv, logic [15:0] hv);
        start_i = st; x_i = xv; h_i = hv;
        @(posedge clk);
        if (!rst_n) begin
            m_busy = 0; m_idx = 0;
        end else if (m_busy) begin
            if (m_idx == NO - 1) begin m_busy = 0; m_idx = 0; end
            else m_idx++;
        end else if (st) begin
            m_busy = 1; m_idx = 0;
            for (int n = 0; n < NP; n++) begin
                m_x[n] = int'(xv[n*4 +: 4]);
                m_h[n] = int'(hv[n*4 +: 4]);
            end
        end
        @(negedge clk);
        check("R8 busy", int'(busy_o), int'(m_busy));
        check("R3 valid", int'(out_valid_o), int'(m_busy));
        check("R4 last", int'(out_last_o), int'(m_busy && m_idx == NO - 1));
        if (m_busy) begin
            check("R3 index", int'(out_idx_o), m_idx);
            check("R5 data", int'(out_data_o), conv(m_idx));
            got[m_idx] = int'(out_data_o);
        end
    endtask

    // full run; garbage on inputs and extra starts during it (R6, R7)
    task automatic run(logic [15:0] xv, logic [15:0] hv, bit disturb);
        step(1'b1, xv, hv);
        for (int c = 1; c < NO; c++) begin
            if (disturb) step(1'b1, 16'($urandom), 16'($urandom));
            else step(1'b0, xv, hv);
        end
        step(1'b0, 16'($urandom), 16'($urandom));
    endtask

    task automatic expect_seq(string req, int e0, int e1, int e2, int e3, int e4, int e5, int e6);
        int e [NO];
        e = '{e0, e1, e2, e3, e4, e5, e6};
        for (int k = 0; k < NO; k++) check(req, got[k], e[k]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        for (int c = 0; c < 3; c++) begin
            step(1'b1, 16'hFFFF, 16'hFFFF);
            check("R1 busy in reset", int'(busy_o), 0);
            check("R1 valid in reset", int'(out_valid_o), 0);
        end
        rst_n = 1'b1;
        step(1'b0, '0, '0);
        check("R1 after release", int'(out_valid_o | out_last_o | busy_o), 0);

        // R5 worked examples
        run(pack4(14, 1, 7, 4), pack4(7, 8, 5, 2), 1'b0);
        expect_seq("R5 example A", 98, 119, 127, 117, 69, 34, 8);
        run(pack4(9, 2, 4, 1), pack4(3, 1, 3, 4), 1'b1);
        expect_seq("R5 example B R6 R7", 27, 15, 41, 49, 21, 19, 4);
        run(pack4(5, 2, 1, 4), pack4(2, 6, 6, 7), 1'b0);
        expect_seq("R5 example C", 10, 34, 44, 61, 44, 31, 28);

        // R9 extremes
        run(16'hFFFF, 16'hFFFF, 1'b1);
        expect_seq("R9 all fifteen", 225, 450, 675, 900, 675, 450, 225);
        run(16'h0000, 16'h0000, 1'b1);
        expect_seq("R9 all zero", 0, 0, 0, 0, 0, 0, 0);

        // random vectors, back-to-back (R8) and with idle gaps
        for (int t = 0; t < 40; t++) begin
            run(16'($urandom), 16'($urandom), t[0]);
            if (t % 3 == 0) step(1'b0, '0, '0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule